// File: doc/BRIEF.md
# Accumulator Round and Saturate Unit

This block finishes a wide accumulator value before it is stored or passed on. It takes a 40-bit accumulator word and applies one operation to it in a single cycle. The operation can round the value to the 16-bit boundary, clamp an overflowed value to the largest 32-bit signed magnitude, or re-derive the overflow flag from the value. The result and an updated overflow flag are held in an output register.

Rounding adds one half at bit 15 and keeps the low sixteen bits that result, so it does not clear them. A mode input chooses how an exact half is treated. In the default mode the half goes to the even neighbour. In the other mode it always rounds up. Saturation takes effect only in the cycle it is requested, and only when the incoming overflow flag is set. A strobe qualifies every operation. When the strobe is low, the register holds its contents.

Top module: `accrs_unit`

## Requirements
- R1: After reset the output value is 0 and the output overflow flag is 0.
- R2: Operation code 0 (round) writes the input plus 0x8000, modulo 2^40, whenever input bits 15:0 are not exactly 0x8000. The resulting low bits are kept.
- R3: When round_bias is 0 (unbiased), a round with input bits 15:0 equal to 0x8000 writes the upper 24 bits rounded to the nearest even value, and the low 16 bits become zero.
- R4: When round_bias is 1 (biased), a round with input bits 15:0 equal to 0x8000 writes the upper 24 bits plus one, modulo 2^24, and the low 16 bits become zero.
- R5: After a round, the output flag is 1 exactly when result bits 39:31 are neither all zeros nor all ones.
- R6: Operation code 1 (saturate) with ovf_in equal to 0 writes the input value unchanged.
- R7: Saturate with ovf_in equal to 1 writes 0x00_7FFF_FFFF when input bit 39 is 0, and 0xFF_8000_0000 when input bit 39 is 1.
- R8: Saturate writes ovf_in to the output flag unchanged. Saturation leaves no lasting mode behind, so the next operation behaves as if no saturate had preceded it.
- R9: Operation code 2 (flag check) writes the input value unchanged, with the flag computed from bits 39:31 of that input as in R5.
- R10: When op_valid is 0, or when the operation code is 3 (reserved), both outputs hold their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Qualifies the operation in this cycle |
| op_sel | input | 2 | 0 round, 1 saturate, 2 flag check, 3 reserved |
| round_bias | input | 1 | 0 unbiased (half to even), 1 biased (half up) |
| acc_in | input | 40 | Accumulator value to process |
| ovf_in | input | 1 | Incoming overflow flag |
| acc_out | output | 40 | Registered result value |
| ovf_out | output | 1 | Registered overflow flag |

## Verification
The hardest cases to reach are the exact midpoint combined with a carry that ripples through all 24 upper bits and wraps past bit 39. Next to that is a rounding carry that moves the value across the 32-bit signed boundary, so that the flag changes. The stimulus fixes the upper 24 bits at 0xFFFFFF, 0x007FFF and 0xFFFF7F, among other patterns, and pairs each with a swept low half-word. The low half-word covers every 257th value plus 0x7FFF, 0x8000 and 0x8001. Saturation and the flag check use walking-one and walking-zero words, so that the sign bit and each guard bit are tried alone.

// File: rtl/accrs_pkg.sv
package accrs_pkg;
    parameter int ACC_W_DEF   = 40;
    parameter int FRAC_W_DEF  = 16;
    parameter int GUARD_W_DEF = 9;

    typedef enum logic [1:0] {
        OP_ROUND = 2'd0,
        OP_SAT   = 2'd1,
        OP_FLAG  = 2'd2,
        OP_RSVD  = 2'd3
    } op_e;
endpackage

// File: rtl/accrs_round.sv
module accrs_round #(
    parameter int ACC_W  = accrs_pkg::ACC_W_DEF,
    parameter int FRAC_W = accrs_pkg::FRAC_W_DEF
) (
    input  logic [ACC_W-1:0] val,
    input  logic             bias,
    output logic [ACC_W-1:0] res
);
    localparam logic [ACC_W-1:0] HALF = {{(ACC_W-1){1'b0}}, 1'b1} << (FRAC_W - 1);

    logic [ACC_W-1:0] sum;
    logic             tie;

    always_comb begin
        sum = val + HALF;
        tie = (val[FRAC_W-1:0] == HALF[FRAC_W-1:0]);
        res = sum;
        // exact half in unbiased mode: clear the new LSB -> even result
        if (tie && !bias) begin
            res[FRAC_W] = 1'b0;
        end
    end
endmodule

// File: rtl/accrs_ovf_det.sv
module accrs_ovf_det #(
    parameter int ACC_W   = accrs_pkg::ACC_W_DEF,
    parameter int GUARD_W = accrs_pkg::GUARD_W_DEF
) (
    input  logic [ACC_W-1:0] val,
    output logic             ovf
);
    logic [GUARD_W-1:0] guard;

    always_comb begin
        guard = val[ACC_W-1 -: GUARD_W];
        ovf   = !((&guard) || !(|guard));
    end
endmodule

// File: rtl/accrs_sat.sv
module accrs_sat #(
    parameter int ACC_W   = accrs_pkg::ACC_W_DEF,
    parameter int GUARD_W = accrs_pkg::GUARD_W_DEF
) (
    input  logic [ACC_W-1:0] val,
    input  logic             ovf,
    output logic [ACC_W-1:0] res
);
    localparam int SPAN = ACC_W - GUARD_W;
    localparam logic [ACC_W-1:0] POS_LIM = {{GUARD_W{1'b0}}, {SPAN{1'b1}}};
    localparam logic [ACC_W-1:0] NEG_LIM = ~POS_LIM;

    always_comb begin
        if (!ovf) begin
            res = val;
        end else if (val[ACC_W-1]) begin
            res = NEG_LIM;
        end else begin
            res = POS_LIM;
        end
    end
endmodule

// File: rtl/accrs_unit.sv
module accrs_unit #(
    parameter int ACC_W   = accrs_pkg::ACC_W_DEF,
    parameter int FRAC_W  = accrs_pkg::FRAC_W_DEF,
    parameter int GUARD_W = accrs_pkg::GUARD_W_DEF
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [1:0]       op_sel,
    input  logic             round_bias,
    input  logic [ACC_W-1:0] acc_in,
    input  logic             ovf_in,
    output logic [ACC_W-1:0] acc_out,
    output logic             ovf_out
);
    import accrs_pkg::*;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic             ovf;
    } state_t;

    state_t           st_d, st_q;
    logic [ACC_W-1:0] rnd_val;
    logic [ACC_W-1:0] sat_val;
    logic             rnd_ovf;
    logic             in_ovf;
    op_e              op;

    accrs_round #(.ACC_W(ACC_W), .FRAC_W(FRAC_W)) round_i (
        .val (acc_in),
        .bias(round_bias),
        .res (rnd_val)
    );

    accrs_sat #(.ACC_W(ACC_W), .GUARD_W(GUARD_W)) sat_i (
        .val(acc_in),
        .ovf(ovf_in),
        .res(sat_val)
    );

    accrs_ovf_det #(.ACC_W(ACC_W), .GUARD_W(GUARD_W)) rnd_det_i (
        .val(rnd_val),
        .ovf(rnd_ovf)
    );

    accrs_ovf_det #(.ACC_W(ACC_W), .GUARD_W(GUARD_W)) in_det_i (
        .val(acc_in),
        .ovf(in_ovf)
    );

    always_comb begin
        op   = op_e'(op_sel);
        st_d = st_q;
        if (op_valid) begin
            unique case (op)
                OP_ROUND: begin
                    st_d.acc = rnd_val;
                    st_d.ovf = rnd_ovf;
                end
                OP_SAT: begin
                    st_d.acc = sat_val;
                    st_d.ovf = ovf_in;
                end
                OP_FLAG: begin
                    st_d.acc = acc_in;
                    st_d.ovf = in_ovf;
                end
                default: st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_out = st_q.acc;
    assign ovf_out = st_q.ovf;
endmodule

// File: rtl/accrs_unit_chk.sv
module accrs_unit_chk #(
    parameter int ACC_W   = accrs_pkg::ACC_W_DEF,
    parameter int GUARD_W = accrs_pkg::GUARD_W_DEF
) (
    input logic             clk,
    input logic             rst_n,
    input logic             op_valid,
    input logic [1:0]       op_sel,
    input logic [ACC_W-1:0] acc_in,
    input logic             ovf_in,
    input logic [ACC_W-1:0] acc_out,
    input logic             ovf_out
);
    localparam logic [ACC_W-1:0] POS_LIM = {{GUARD_W{1'b0}}, {(ACC_W-GUARD_W){1'b1}}};

    logic hold_req;
    logic sat_req;
    assign hold_req = !op_valid || (op_sel == 2'd3);
    assign sat_req  = op_valid && (op_sel == 2'd1);

    a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        hold_req |=> ($stable(acc_out) && $stable(ovf_out)));

    a_r6_sat_passthru: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_req && !ovf_in) |=> (acc_out == $past(acc_in)));

    a_r7_sat_limit: assert property (@(posedge clk) disable iff (!rst_n)
        (sat_req && ovf_in) |=>
            (acc_out == ($past(acc_in[ACC_W-1]) ? ~POS_LIM : POS_LIM)));

    a_r8_sat_flag_kept: assert property (@(posedge clk) disable iff (!rst_n)
        sat_req |=> (ovf_out == $past(ovf_in)));

    a_r9_flag_check_value: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == 2'd2) |=> (acc_out == $past(acc_in)));

    a_r5_guard_uniform: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_sel == 2'd0) |=>
            (ovf_out == !($countones(acc_out[ACC_W-1 -: GUARD_W]) == 0 ||
                          $countones(acc_out[ACC_W-1 -: GUARD_W]) == GUARD_W)));
endmodule

bind accrs_unit accrs_unit_chk #(.ACC_W(ACC_W), .GUARD_W(GUARD_W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .op_valid(op_valid),
    .op_sel  (op_sel),
    .acc_in  (acc_in),
    .ovf_in  (ovf_in),
    .acc_out (acc_out),
    .ovf_out (ovf_out)
);

// File: tb/accrs_unit_tb_top.sv
`timescale 1ns/1ps
module accrs_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [1:0]  op_sel = 2'd0;
    logic        round_bias = 1'b0;
    logic [39:0] acc_in = '0;
    logic        ovf_in = 1'b0;
    logic [39:0] acc_out;
    logic        ovf_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    accrs_unit dut_i (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
        .round_bias(round_bias), .acc_in(acc_in), .ovf_in(ovf_in),
        .acc_out(acc_out), .ovf_out(ovf_out)
    );

    function automatic logic [39:0] round_ref(logic [39:0] v, logic b);
        logic [23:0] up = v[39:16];
        logic [15:0] lo = v[15:0];
        if (lo == 16'h8000) begin
            if (b || up[0]) up = up + 24'd1;
            return {up, 16'h0000};
        end else if (lo > 16'h8000) begin
            return {up + 24'd1, lo - 16'h8000};
        end
        return {up, lo + 16'h8000};
    endfunction

    function automatic logic flag_ref(logic [39:0] v);
        return !(v[39:31] == 9'h000 || v[39:31] == 9'h1FF);
    endfunction

    function automatic logic [39:0] sat_ref(logic [39:0] v, logic f);
        if (!f) return v;
        return v[39] ? 40'hFF_8000_0000 : 40'h00_7FFF_FFFF;
    endfunction

    task automatic expect_out(string req, logic [39:0] ea, logic ef);
        checks++;
        if (acc_out !== ea || ovf_out !== ef) begin
            fails++;
            $display("FAIL %s: acc_out=%h ovf_out=%b expected acc=%h ovf=%b",
                     req, acc_out, ovf_out, ea, ef);
        end
    endtask

    // called at a negedge; applies op, checks at the next negedge
    task automatic apply(logic vld, logic [1:0] op, logic [39:0] v, logic f, logic b,
                         string req, logic [39:0] ea, logic ef);
        op_valid = vld; op_sel = op; acc_in = v; ovf_in = f; round_bias = b;
        @(negedge clk);
        expect_out(req, ea, ef);
    endtask

    task automatic do_round(logic [39:0] v, logic b);
        logic [39:0] e = round_ref(v, b);
        string req;
        if (v[15:0] != 16'h8000) req = "R2";
        else req = b ? "R4" : "R3";
        apply(1'b1, 2'd0, v, 1'b0, b, req, e, flag_ref(e));
        checks++;
        if (ovf_out !== flag_ref(e)) begin
            fails++;
            $display("FAIL R5: ovf_out=%b expected %b", ovf_out, flag_ref(e));
        end
    endtask

    initial begin
        logic [23:0] uppers [6];
        logic [15:0] mids [3];
        logic [39:0] w;
        uppers = '{24'h000000, 24'h000001, 24'h007FFF, 24'hFFFFFF, 24'hFFFF7F, 24'h123456};
        mids   = '{16'h7FFF, 16'h8000, 16'h8001};

        repeat (3) @(negedge clk);
        expect_out("R1", 40'h0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        expect_out("R1", 40'h0, 1'b0);

        // table corners for R2/R3/R4
        apply(1'b1, 2'd0, 40'h00_0000_8000, 1'b0, 1'b0, "R3", 40'h00_0000_0000, 1'b0);
        apply(1'b1, 2'd0, 40'h00_0001_8000, 1'b0, 1'b0, "R3", 40'h00_0002_0000, 1'b0);
        apply(1'b1, 2'd0, 40'h00_0000_8000, 1'b0, 1'b1, "R4", 40'h00_0001_0000, 1'b0);
        apply(1'b1, 2'd0, 40'h00_0000_8001, 1'b0, 1'b0, "R2", 40'h00_0001_0001, 1'b0);
        apply(1'b1, 2'd0, 40'h00_0000_7FFF, 1'b0, 1'b1, "R2", 40'h00_0000_FFFF, 1'b0);
        apply(1'b1, 2'd0, 40'hFF_FFFF_8000, 1'b0, 1'b1, "R4", 40'h00_0000_0000, 1'b0);
        apply(1'b1, 2'd0, 40'h00_7FFF_8000, 1'b0, 1'b1, "R5", 40'h00_8000_0000, 1'b1);

        // round sweep
        for (int m = 0; m < 2; m++) begin
            for (int u = 0; u < 6; u++) begin
                for (int i = 0; i < 256; i++) do_round({uppers[u], 16'(i * 257)}, m[0]);
                for (int k = 0; k < 3; k++) do_round({uppers[u], mids[k]}, m[0]);
            end
        end

        // saturate and flag check with walking patterns
        for (int bt = 0; bt < 40; bt++) begin
            for (int pol = 0; pol < 2; pol++) begin
                w = 40'h1 << bt;
                if (pol != 0) w = ~w;
                for (int f = 0; f < 2; f++) begin
                    apply(1'b1, 2'd1, w, f[0], 1'b0, f[0] ? "R7" : "R6", sat_ref(w, f[0]), f[0]);
                    checks++;
                    if (ovf_out !== f[0]) begin
                        fails++;
                        $display("FAIL R8: ovf_out=%b expected %b", ovf_out, f[0]);
                    end
                end
                apply(1'b1, 2'd2, w, 1'b0, 1'b0, "R9", w, flag_ref(w));
            end
        end

        // no lasting saturate mode: round right after a saturate
        apply(1'b1, 2'd1, 40'h05_0000_0000, 1'b1, 1'b0, "R7", 40'h00_7FFF_FFFF, 1'b1);
        apply(1'b1, 2'd0, 40'h05_0000_0000, 1'b1, 1'b0, "R8", 40'h05_0000_8000, 1'b1);
        apply(1'b1, 2'd2, 40'h00_0000_1234, 1'b1, 1'b0, "R8", 40'h00_0000_1234, 1'b0);

        // hold cases
        apply(1'b0, 2'd1, 40'h80_0000_0000, 1'b1, 1'b0, "R10", 40'h00_0000_1234, 1'b0);
        apply(1'b1, 2'd3, 40'hAB_CDEF_0123, 1'b1, 1'b1, "R10", 40'h00_0000_1234, 1'b0);
        apply(1'b0, 2'd0, 40'h7F_FFFF_8000, 1'b0, 1'b1, "R10", 40'h00_0000_1234, 1'b0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule